// File: doc/BRIEF.md
# Page-aligned flash program splitter

This block writes a byte stream of any length into a serial NOR flash, starting at any byte address. A request gives a start address and a byte count. The block cuts the stream into program commands, and no command runs past the end of a 256-byte page. The first command ends at the page boundary that follows the start address. Each later command covers at most one full page, at an address worked out again from the start address and the number of bytes already sent.

Before each command the block polls the device status until the busy flag is clear, then issues a write-enable command. It then sends the program opcode, a 24-bit address and the data bytes. The data bytes come from a valid/ready input stream, and that stream is only accepted while the data phase of a program frame is open. An external serializer moves the bytes on the wire one at a time through a request/acknowledge handshake. The block drives chip select for each frame.

A request of zero length completes at once. A request that would run past the end of the device is refused, and nothing is sent. A status wait that never sees the device idle ends the request with a timeout error. A running count of the data bytes written is always visible, and at completion it holds the total.

Top module: `flash_page_prog`

## Requirements
- R1: The first program frame of a request carries min(256 − (start address mod 256), length) data bytes, so no frame crosses a 256-byte page boundary.
- R2: Each later program frame carries min(256, bytes still to send) data bytes, and its address equals the start address plus the number of data bytes already sent.
- R3: Every program frame is preceded by one or more status frames, then a one-byte write-enable frame (byte 0x06). A status frame is byte 0x05 followed by one filler byte, and the byte returned during the filler has bit 0 = 1 for busy. Polling repeats until a read returns bit 0 = 0.
- R4: A program frame is byte 0x02, then address bits 23:16, 15:8 and 7:0 in that order, then the data bytes in the order they were taken from the input stream.
- R5: A request with length 0 raises `done` in the cycle after `start`, sends no frame, reports no error and leaves `bytes_written` at 0.
- R6: If start address + length is greater than DEV_BYTES, `done` rises in the cycle after `start` with `err_range` = 1 and no frame is sent. A range that ends exactly at DEV_BYTES is accepted.
- R7: `bytes_written` is cleared when a request is accepted. It rises by one for each data byte sent and never counts opcode, address or filler bytes. At `done` it equals the number of data bytes written.
- R8: `spi_cs_n` stays low for the whole of a frame. It goes high for at least one cycle between frames, and it stays high while the block is idle.
- R9: `in_ready` is high only in the data phase of a program frame while no byte is waiting for the serializer, so only bytes that are accepted get sent.
- R10: After POLL_LIMIT busy status reads in a row, the request ends with `done` and `err_timeout` = 1. No write-enable frame and no program frame are sent, and `bytes_written` is 0.
- R11: `spi_req` stays high with `spi_tx` unchanged until `spi_ack`. Each cycle with both `spi_req` and `spi_ack` high moves one byte. `spi_req` is never high while `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a request; sampled only while idle |
| start_addr | input | ADDR_W | First flash byte address |
| start_len | input | LEN_W | Number of data bytes to write |
| busy | output | 1 | High from the accepted start until done |
| done | output | 1 | One-cycle completion pulse |
| err_range | output | 1 | Request refused as out of range; held until the next start |
| err_timeout | output | 1 | Status wait timed out; held until the next start |
| bytes_written | output | LEN_W | Running count of data bytes sent |
| in_valid | input | 1 | Input data byte valid |
| in_data | input | 8 | Input data byte |
| in_ready | output | 1 | Block accepts the input byte |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_req | output | 1 | Byte transfer request to the serializer |
| spi_tx | output | 8 | Byte to shift out |
| spi_ack | input | 1 | Serializer finished the current byte |
| spi_rx | input | 8 | Byte shifted in, valid with spi_ack |

## Verification
A refused or zero-length request must show `done` in the first cycle after `start`, so the bench samples at the very next falling edge. Each serializer byte completes on the rising edge at which `spi_ack` meets `spi_req`. The bench's serializer model raises `spi_ack` at a falling edge and clears it at the next one, so each byte takes two cycles, and the model captures `spi_tx` while it is stable. Frames are closed and checked at the first falling edge that sees `spi_cs_n` high, which is the one-cycle gap before the next frame or before `done`. The completion checks therefore run when `done` is seen, with every frame already decoded.

// File: rtl/fpp_pkg.sv
// Shared constants and the sequencer state type for the page program splitter.
package fpp_pkg;
    localparam logic [7:0] OPC_STATUS = 8'h05;   // status read opcode
    localparam logic [7:0] OPC_WEN    = 8'h06;   // write enable opcode
    localparam logic [7:0] OPC_PROG   = 8'h02;   // page program opcode
    localparam logic [7:0] OPC_FILL   = 8'h00;   // filler byte during a status read
    localparam int         BUSY_BIT   = 0;       // busy flag position in the status byte

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL_OP,
        ST_POLL_RD,
        ST_WREN,
        ST_PP_OP,
        ST_PP_A2,
        ST_PP_A1,
        ST_PP_A0,
        ST_PP_DATA,
        ST_GAP,
        ST_FIN
    } fpp_state_e;
endpackage

// File: rtl/fpp_chunk_calc.sv
// Works out the length of the next program chunk: the room left in the
// current page or the bytes still to send, whichever is smaller.
// Assumes LEN_W >= PAGE_W + 1.
module fpp_chunk_calc #(
    parameter int PAGE_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic [PAGE_W-1:0] page_off,
    input  logic [LEN_W-1:0]  remain,
    output logic [PAGE_W:0]   chunk_len
);
    localparam logic [PAGE_W:0] PAGE_BYTES = {1'b1, {PAGE_W{1'b0}}};

    logic [PAGE_W:0] room;

    // Pick the smaller of page room and remaining count.
    always_comb begin
        room = PAGE_BYTES - {1'b0, page_off};
        if (remain < LEN_W'(room)) begin
            chunk_len = remain[PAGE_W:0];
        end else begin
            chunk_len = room;
        end
    end
endmodule

// File: rtl/fpp_poll_guard.sv
// Counts busy status reads in the current wait. It flags the read that
// would be the LIMIT-th busy read in a row. Assumes LIMIT >= 1.
module fpp_poll_guard #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Busy read counter, cleared for each new wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/fpp_ctrl.sv
// Frame sequencer. For each chunk it runs a status wait, a write enable
// and one program frame, and it closes chip select for one cycle between
// frames. Assumes ADDR_W <= 24 and a serializer that moves one byte on
// each cycle with spi_req and spi_ack both high.
module fpp_ctrl
    import fpp_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int          LEN_W     = 16,
    parameter int          PAGE_W    = 8,
    parameter int unsigned DEV_BYTES = 32'h0010_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    output logic              busy,
    output logic              done,
    output logic              err_range,
    output logic              err_timeout,
    output logic [LEN_W-1:0]  bytes_written,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              spi_cs_n,
    output logic              spi_req,
    output logic [7:0]        spi_tx,
    input  logic              spi_ack,
    input  logic [7:0]        spi_rx,
    input  logic [PAGE_W:0]   chunk_len,
    output logic [PAGE_W-1:0] page_off,
    output logic [LEN_W-1:0]  remain,
    output logic              poll_clr,
    output logic              poll_inc,
    input  logic              poll_expired
);
    localparam logic [32:0] DEV_LIM = 33'(DEV_BYTES);

    fpp_state_e        state_q, gap_next_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic [PAGE_W:0]   chunk_q;
    logic [LEN_W-1:0]  count_q;
    logic              pend_q;
    logic [7:0]        data_q;
    logic              err_range_q, err_tmo_q;

    logic              in_frame, fire, dev_busy, accept;
    logic [23:0]       addr24;
    logic [32:0]       end_sum;
    logic [6:0]        rx_unused;

    assign addr24    = 24'(addr_q);
    assign end_sum   = 33'(start_addr) + 33'(start_len);
    assign dev_busy  = spi_rx[BUSY_BIT];
    assign rx_unused = spi_rx[7:1];

    // Decode frame membership, byte request and input readiness from state.
    always_comb begin
        in_frame = (state_q == ST_POLL_OP) || (state_q == ST_POLL_RD) ||
                   (state_q == ST_WREN)    || (state_q == ST_PP_OP)   ||
                   (state_q == ST_PP_A2)   || (state_q == ST_PP_A1)   ||
                   (state_q == ST_PP_A0)   || (state_q == ST_PP_DATA);
        spi_req  = (state_q == ST_PP_DATA) ? pend_q : in_frame;
        in_ready = (state_q == ST_PP_DATA) && !pend_q;
    end

    // Select the byte to shift out for the current state.
    always_comb begin
        unique case (state_q)
            ST_POLL_OP: spi_tx = OPC_STATUS;
            ST_POLL_RD: spi_tx = OPC_FILL;
            ST_WREN:    spi_tx = OPC_WEN;
            ST_PP_OP:   spi_tx = OPC_PROG;
            ST_PP_A2:   spi_tx = addr24[23:16];
            ST_PP_A1:   spi_tx = addr24[15:8];
            ST_PP_A0:   spi_tx = addr24[7:0];
            ST_PP_DATA: spi_tx = data_q;
            default:    spi_tx = 8'h00;
        endcase
    end

    assign fire     = spi_req && spi_ack;
    assign accept   = in_valid && in_ready;
    assign spi_cs_n = !in_frame;
    assign poll_inc = (state_q == ST_POLL_RD) && fire && dev_busy;
    assign poll_clr = ((state_q == ST_IDLE) && start) ||
                      ((state_q == ST_POLL_RD) && fire && !dev_busy);

    // Main sequencer: request intake, frame stepping and chunk bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            gap_next_q  <= ST_IDLE;
            addr_q      <= '0;
            remain_q    <= '0;
            chunk_q     <= '0;
            count_q     <= '0;
            pend_q      <= 1'b0;
            data_q      <= '0;
            err_range_q <= 1'b0;
            err_tmo_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        err_range_q <= 1'b0;
                        err_tmo_q   <= 1'b0;
                        count_q     <= '0;
                        addr_q      <= start_addr;
                        remain_q    <= start_len;
                        if (start_len == '0) begin
                            state_q <= ST_FIN;
                        end else if (end_sum > DEV_LIM) begin
                            err_range_q <= 1'b1;
                            state_q     <= ST_FIN;
                        end else begin
                            state_q <= ST_POLL_OP;
                        end
                    end
                end
                ST_POLL_OP: if (fire) state_q <= ST_POLL_RD;
                ST_POLL_RD: begin
                    if (fire) begin
                        state_q <= ST_GAP;
                        if (!dev_busy) begin
                            gap_next_q <= ST_WREN;
                        end else if (poll_expired) begin
                            err_tmo_q  <= 1'b1;
                            gap_next_q <= ST_FIN;
                        end else begin
                            gap_next_q <= ST_POLL_OP;
                        end
                    end
                end
                ST_WREN: begin
                    if (fire) begin
                        chunk_q    <= chunk_len;
                        gap_next_q <= ST_PP_OP;
                        state_q    <= ST_GAP;
                    end
                end
                ST_PP_OP: if (fire) state_q <= ST_PP_A2;
                ST_PP_A2: if (fire) state_q <= ST_PP_A1;
                ST_PP_A1: if (fire) state_q <= ST_PP_A0;
                ST_PP_A0: if (fire) state_q <= ST_PP_DATA;
                ST_PP_DATA: begin
                    if (accept) begin
                        data_q <= in_data;
                        pend_q <= 1'b1;
                    end
                    if (fire) begin
                        pend_q   <= 1'b0;
                        addr_q   <= addr_q + 1'b1;
                        remain_q <= remain_q - 1'b1;
                        chunk_q  <= chunk_q - 1'b1;
                        count_q  <= count_q + 1'b1;
                        if (chunk_q == (PAGE_W+1)'(1)) begin
                            state_q    <= ST_GAP;
                            gap_next_q <= (remain_q == LEN_W'(1)) ? ST_FIN : ST_POLL_OP;
                        end
                    end
                end
                ST_GAP: state_q <= gap_next_q;
                ST_FIN: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy          = (state_q != ST_IDLE);
    assign done          = (state_q == ST_FIN);
    assign err_range     = err_range_q;
    assign err_timeout   = err_tmo_q;
    assign bytes_written = count_q;
    assign page_off      = addr_q[PAGE_W-1:0];
    assign remain        = remain_q;
endmodule

// File: rtl/flash_page_prog.sv
// Top of the page program splitter. It connects the frame sequencer, the
// chunk length calculator and the status poll guard. Page size is
// 2**PAGE_W bytes; the device holds DEV_BYTES bytes.
module flash_page_prog #(
    parameter int          ADDR_W     = 24,
    parameter int          LEN_W      = 16,
    parameter int          PAGE_W     = 8,
    parameter int unsigned DEV_BYTES  = 32'h0010_0000,
    parameter int          POLL_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    output logic              busy,
    output logic              done,
    output logic              err_range,
    output logic              err_timeout,
    output logic [LEN_W-1:0]  bytes_written,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              spi_cs_n,
    output logic              spi_req,
    output logic [7:0]        spi_tx,
    input  logic              spi_ack,
    input  logic [7:0]        spi_rx
);
    logic [PAGE_W:0]   chunk_len;
    logic [PAGE_W-1:0] page_off;
    logic [LEN_W-1:0]  remain;
    logic              poll_clr, poll_inc, poll_expired;

    fpp_ctrl #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W), .DEV_BYTES(DEV_BYTES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_len(start_len), .busy(busy), .done(done), .err_range(err_range),
        .err_timeout(err_timeout), .bytes_written(bytes_written),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .spi_cs_n(spi_cs_n), .spi_req(spi_req), .spi_tx(spi_tx),
        .spi_ack(spi_ack), .spi_rx(spi_rx), .chunk_len(chunk_len),
        .page_off(page_off), .remain(remain), .poll_clr(poll_clr),
        .poll_inc(poll_inc), .poll_expired(poll_expired)
    );

    fpp_chunk_calc #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_chunk (
        .page_off(page_off), .remain(remain), .chunk_len(chunk_len)
    );

    fpp_poll_guard #(.LIMIT(POLL_LIMIT)) u_guard (
        .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc),
        .expired(poll_expired)
    );
endmodule

// File: rtl/flash_page_prog_chk.sv
// Protocol checker for the page program splitter, bound to the top.
module flash_page_prog_chk #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] start_addr,
    input logic [LEN_W-1:0]  start_len,
    input logic              busy,
    input logic              done,
    input logic              err_range,
    input logic              err_timeout,
    input logic [LEN_W-1:0]  bytes_written,
    input logic              in_valid,
    input logic [7:0]        in_data,
    input logic              in_ready,
    input logic              spi_cs_n,
    input logic              spi_req,
    input logic [7:0]        spi_tx,
    input logic              spi_ack,
    input logic [7:0]        spi_rx
);
    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));

    // R11
    req_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |-> !spi_cs_n);

    // R9
    ready_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!spi_cs_n && !spi_req));

    // R5
    zero_len_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && start_len == '0) |=> (done && !err_range && !err_timeout));

    // R8
    idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((bytes_written == $past(bytes_written)) ||
                  (bytes_written == $past(bytes_written) + 1'b1)));
endmodule

bind flash_page_prog flash_page_prog_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/flash_page_prog_tb.sv
module flash_page_prog_tb;
    localparam int          ADDR_W     = 24;
    localparam int          LEN_W      = 16;
    localparam int          PAGE_W     = 8;
    localparam int unsigned DEV_BYTES  = 4096;
    localparam int          POLL_LIMIT = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic              start;
    logic [ADDR_W-1:0] start_addr;
    logic [LEN_W-1:0]  start_len;
    logic              busy, done, err_range, err_timeout;
    logic [LEN_W-1:0]  bytes_written;
    logic              in_valid;
    logic [7:0]        in_data;
    logic              in_ready;
    logic              spi_cs_n, spi_req;
    logic [7:0]        spi_tx;
    logic              spi_ack;
    logic [7:0]        spi_rx;

    flash_page_prog #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W),
        .DEV_BYTES(DEV_BYTES), .POLL_LIMIT(POLL_LIMIT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_len(start_len), .busy(busy), .done(done), .err_range(err_range),
        .err_timeout(err_timeout), .bytes_written(bytes_written),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .spi_cs_n(spi_cs_n), .spi_req(spi_req), .spi_tx(spi_tx),
        .spi_ack(spi_ack), .spi_rx(spi_rx)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // serializer / flash model state
    logic [7:0] fbuf [0:299];
    int  flen = 0;
    bit  stuck = 0;
    int  busy_left = 0;
    bit  wel = 0, idle_seen = 0, cs_low_seen = 0;
    int  polls = 0, wrens = 0, progs = 0, sent = 0;
    int  exp_base = 0, exp_len = 0;

    // input feeder state
    bit  feed_on = 0, throttle = 0, rdy_seen = 0;
    int  feed_len = 0, fed = 0;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 13 + (i >> 8) * 5 + 33) & 255);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Decode one completed frame and check it.
    task automatic take_frame();
        int a, dn, room, want, bad;
        if (flen == 2 && fbuf[0] == 8'h05) begin
            polls++;
            if (stuck || busy_left > 0) begin
                if (busy_left > 0) busy_left--;
            end else begin
                idle_seen = 1;
            end
        end else if (flen == 1 && fbuf[0] == 8'h06) begin
            wrens++;
            wel = 1;
        end else if (flen >= 5 && fbuf[0] == 8'h02) begin
            progs++;
            a  = {8'h00, fbuf[1], fbuf[2], fbuf[3]};
            dn = flen - 4;
            chk(wel, "R3 write enable before program", wel, 1);
            chk(idle_seen, "R3 idle status before program", idle_seen, 1);
            chk(a == exp_base + sent, "R2 R4 program address", a, exp_base + sent);
            room = 256 - (a % 256);
            want = (exp_len - sent < room) ? exp_len - sent : room;
            chk(dn == want, (sent == 0) ? "R1 first chunk length" : "R2 later chunk length", dn, want);
            bad = 0;
            for (int k = 0; k < dn && k < 296; k++) begin
                if (fbuf[4 + k] != pat(sent + k)) bad++;
            end
            chk(bad == 0, "R4 data bytes in order", bad, 0);
            sent += dn;
            wel = 0;
            idle_seen = 0;
            busy_left = 2;
        end else begin
            chk(0, "R8 R3 unrecognised frame", flen, 0);
        end
    endtask

    // Serializer model: ack each requested byte after one cycle, frame on cs_n.
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            spi_ack = 1'b0;
            spi_rx  = 8'h00;
            flen    = 0;
        end else begin
            if (!spi_cs_n) cs_low_seen = 1;
            if (spi_cs_n && flen > 0) begin
                take_frame();
                flen = 0;
            end
            if (spi_ack) begin
                spi_ack = 1'b0;
            end else if (spi_req) begin
                if (spi_cs_n) chk(0, "R11 request with cs_n high", 1, 0);
                if (flen < 300) fbuf[flen] = spi_tx;
                spi_rx = (flen == 1 && fbuf[0] == 8'h05) ?
                         {7'b0, (stuck || busy_left > 0)} : 8'h00;
                flen++;
                spi_ack = 1'b1;
            end
        end
    end

    // Input stream feeder: offer pattern bytes, count accepted ones.
    always @(negedge clk) begin
        if (feed_on) begin
            if (in_valid && rdy_seen) fed++;
            in_valid = (fed < feed_len) && !(throttle && (cyc % 3 == 1));
            in_data  = pat(fed);
            rdy_seen = in_ready;
        end else begin
            in_valid = 1'b0;
            in_data  = 8'h00;
            rdy_seen = 1'b0;
        end
    end

    task automatic run_op(input int addr, input int len, input bit thr, input int pre_busy,
                          input bit exp_rng, input bit exp_tmo);
        int exp_cnt, exp_frames;
        sent = 0; exp_base = addr; exp_len = len;
        polls = 0; wrens = 0; progs = 0; cs_low_seen = 0;
        busy_left = pre_busy; wel = 0; idle_seen = 0;
        fed = 0; feed_len = len; throttle = thr; feed_on = 1;
        start = 1'b1; start_addr = ADDR_W'(addr); start_len = LEN_W'(len);
        @(negedge clk);
        start = 1'b0;
        if (len == 0) chk(done == 1'b1, "R5 done one cycle after start", done, 1);
        if (exp_rng)  chk(done == 1'b1, "R6 refusal one cycle after start", done, 1);
        while (!done) @(negedge clk);
        chk(err_range == exp_rng, "R6 range error flag", err_range, exp_rng);
        chk(err_timeout == exp_tmo, "R10 timeout flag", err_timeout, exp_tmo);
        exp_cnt = (exp_rng || exp_tmo) ? 0 : len;
        chk(bytes_written == LEN_W'(exp_cnt), "R7 bytes written at done", bytes_written, exp_cnt);
        chk(sent == exp_cnt, "R2 data bytes sent", sent, exp_cnt);
        chk(fed == exp_cnt, "R9 bytes taken from stream", fed, exp_cnt);
        if (len == 0 || exp_rng) begin
            chk(cs_low_seen == 0, "R5 R6 no frame sent", cs_low_seen, 0);
        end else if (exp_tmo) begin
            chk(polls == POLL_LIMIT, "R10 status reads before timeout", polls, POLL_LIMIT);
            chk(wrens + progs == 0, "R10 no enable or program frame", wrens + progs, 0);
        end else begin
            exp_frames = ((addr % 256) + len + 255) / 256;
            chk(progs == exp_frames, "R1 program frame count", progs, exp_frames);
            chk(wrens == progs, "R3 one enable per program frame", wrens, progs);
        end
        feed_on = 0;
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0 && spi_cs_n == 1'b1, "R8 idle with cs_n high", {busy, spi_cs_n}, 1);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1-R11 run: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        int offs [4];
        int lens [6];
        bit thr;
        offs = '{0, 1, 128, 255};
        lens = '{1, 2, 255, 256, 257, 600};
        rst_n = 1'b0; start = 1'b0; start_addr = '0; start_len = '0;
        in_valid = 1'b0; in_data = 8'h00; spi_ack = 1'b0; spi_rx = 8'h00;
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R8 reset cs_n high", spi_cs_n, 1);
        chk(busy == 1'b0 && done == 1'b0, "R5 reset idle", {busy, done}, 0);
        chk(bytes_written == '0, "R7 reset count", bytes_written, 0);
        chk(in_ready == 1'b0, "R9 reset not ready", in_ready, 0);
        chk(spi_req == 1'b0, "R11 reset no request", spi_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(16, 0, 0, 0, 0, 0);          // R5 zero length
        run_op(3897, 200, 0, 0, 1, 0);      // R6 one past the end
        run_op(3896, 200, 1, 1, 0, 0);      // R6 ends exactly at the device end

        thr = 0;
        foreach (offs[i]) begin
            foreach (lens[j]) begin
                run_op(32'h300 + offs[i], lens[j], thr, (i + j) % 3, 0, 0);
                thr = !thr;
            end
        end

        stuck = 1;
        run_op(0, 10, 0, 0, 0, 1);          // R10 status never idle
        stuck = 0;
        run_op(500, 40, 0, 0, 0, 0);        // recovery after timeout

        summary();
        $finish;
    end
endmodule